// File: doc/BRIEF.md
# Decoding-Path Pointer Table with Single-Cycle Row Copy

This block sits beside the stage-update datapath of a list successive-cancellation polar decoder that follows several candidate paths at once. For each path and each intermediate stage it stores a small tag. The tag names the likelihood state-memory that holds that path's values for that stage. When the datapath updates stage s for path l, it reads stage s+1 through the tag of path l. After it writes stage s, the tag of (l, s) is pointed back at memory l. When path selection keeps some paths, drops others and duplicates the rest, every row of tags is replaced by the row of its parent path, all in one clock cycle. No likelihood values are moved.

The block also owns the bit counter of the codeword. From the current bit index it derives the highest stage that must be recomputed. It also reports whether the current bit needs path selection, based on an external frozen/information tag and on whether the bit is the last one. The intermediate stages are 1 to `LOG_N-1`. Stage `LOG_N` is the shared channel memory and stage 0 is the decision level, so neither has tags.

Top module: `path_ptr_table`

## Requirements
- R1: After reset or a `startCw` strobe, every stored tag is 0 and the bit counter is 0.
- R2: Output slot l of `rdPtr` (bits l*PW +: PW) gives the tag of path l at stage `rdStage`, combinationally, for `rdStage` in 1..LOG_N-1. For any other `rdStage` the slot reads 0.
- R3: A `wrEn` pulse with path w and stage s in 1..LOG_N-1 makes tag (w, s) equal to w from the next cycle on, and leaves all other tags unchanged. A `wrEn` with stage 0 or a stage of LOG_N and above changes no tag.
- R4: A `copyEn` pulse replaces row l with the old row of parent `copyParents[l*PW +: PW]` for every l, in one cycle. Every parent row is read before any row is written, so a parent that is overwritten in the same cycle still supplies its old contents.
- R5: Priority order is `startCw` first, then `copyEn`, then `wrEn`. A write that comes with a copy or a start is dropped.
- R6: `bitIdx` (0-based) increments by one on each `bitDone` pulse and wraps from N-1 to 0. Without `bitDone` it holds its value.
- R7: `topStage` is LOG_N when `bitIdx` is 0. Otherwise it is 1 plus the number of leading zeros of the LOG_N-bit MSB-first form of `bitIdx`, which equals LOG_N minus the position of its highest set bit.
- R8: `selNeeded` is 1 when `bitFrozen` is 0 or `bitIdx` equals N-1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCw | input | 1 | Start of codeword: clears tags and bit counter |
| wrEn | input | 1 | Stage-write strobe |
| wrPath | input | PW | Path that wrote the stage |
| wrStage | input | SW | Stage that was written |
| copyEn | input | 1 | Path-selection row copy strobe |
| copyParents | input | L*PW | Parent path index for each path |
| rdStage | input | SW | Stage whose tags are read |
| rdPtr | output | L*PW | Tag of each path at `rdStage` |
| bitDone | input | 1 | Advance to next bit |
| bitFrozen | input | 1 | Current bit is frozen (1) or information (0) |
| bitIdx | output | LOG_N | Current 0-based bit index |
| topStage | output | SW | Highest stage to recompute for the current bit |
| selNeeded | output | 1 | Path selection and row copy required for this bit |

## Verification
Tag reads, `topStage` and `selNeeded` are combinational, so the bench sets `rdStage`, `bitFrozen` or the counter state and compares them a fraction of a nanosecond later, in the same low clock phase. Writes, copies, starts and counter steps take effect at the next rising edge. The bench therefore drives each strobe for exactly one cycle from a falling edge, lowers it at the following falling edge, and then sweeps every `rdStage` value, including the untagged stages 0 and LOG_N, against its own model of the table. The bit-index sweep visits every index and steps past the wrap, checking both frozen-tag values at each index.

// File: rtl/path_ptr_pkg.sv
package path_ptr_pkg;
  // Strobes issued by the control to the tag storage, already prioritised.
  typedef struct packed {
    logic clearAll;
    logic doCopy;
    logic doWrite;
  } ptr_strobe_t;
endpackage

// File: rtl/path_ptr_ctrl.sv
module path_ptr_ctrl
  import path_ptr_pkg::*;
#(
  parameter int L     = 4,
  parameter int LOG_N = 4,
  localparam int PW   = (L > 1) ? $clog2(L) : 1,
  localparam int SW   = $clog2(LOG_N + 1),
  localparam int NST  = LOG_N - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCw,
  input  logic             wrEn,
  input  logic [SW-1:0]    wrStage,
  input  logic             copyEn,
  input  logic             bitDone,
  input  logic             bitFrozen,
  output ptr_strobe_t      strobe,
  output logic [LOG_N-1:0] bitIdx,
  output logic [SW-1:0]    topStage,
  output logic             selNeeded
);
  localparam logic [SW-1:0]    LAST_STAGE = SW'(NST);
  localparam logic [LOG_N-1:0] LAST_BIT   = '1;

  logic stageOk;
  assign stageOk = (wrStage != '0) && (wrStage <= LAST_STAGE);

  always_comb begin
    strobe.clearAll = startCw;
    strobe.doCopy   = copyEn && !startCw;
    strobe.doWrite  = wrEn && stageOk && !copyEn && !startCw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitIdx <= '0;
    else if (startCw)   bitIdx <= '0;
    else if (bitDone)   bitIdx <= bitIdx + 1'b1;
  end

  // Highest stage to recompute: LOG_N minus position of highest set bit.
  always_comb begin
    logic found;
    found    = 1'b0;
    topStage = SW'(LOG_N);
    for (int b = LOG_N - 1; b >= 0; b--) begin
      if (!found && bitIdx[b]) begin
        found    = 1'b1;
        topStage = SW'(LOG_N - b);
      end
    end
  end

  assign selNeeded = !bitFrozen || (bitIdx == LAST_BIT);
endmodule

// File: rtl/path_ptr_dp.sv
module path_ptr_dp
  import path_ptr_pkg::*;
#(
  parameter int L     = 4,
  parameter int LOG_N = 4,
  localparam int PW   = (L > 1) ? $clog2(L) : 1,
  localparam int SW   = $clog2(LOG_N + 1),
  localparam int NST  = LOG_N - 1,
  localparam int SIW  = (NST > 1) ? $clog2(NST) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ptr_strobe_t     strobe,
  input  logic [PW-1:0]   wrPath,
  input  logic [SW-1:0]   wrStage,
  input  logic [L*PW-1:0] copyParents,
  input  logic [SW-1:0]   rdStage,
  output logic [L*PW-1:0] rdPtr
);
  localparam logic [SW-1:0] LAST_STAGE = SW'(NST);

  logic [PW-1:0] tagMem [L][NST];
  logic [SIW-1:0] wIdx, rIdx;
  logic rdOk;

  assign wIdx = SIW'(wrStage - SW'(1));
  assign rIdx = SIW'(rdStage - SW'(1));
  assign rdOk = (rdStage != '0) && (rdStage <= LAST_STAGE);

  // Non-blocking updates: every parent row is sampled before any write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < L; l++)
        for (int s = 0; s < NST; s++) tagMem[l][s] <= '0;
    end else if (strobe.clearAll) begin
      for (int l = 0; l < L; l++)
        for (int s = 0; s < NST; s++) tagMem[l][s] <= '0;
    end else if (strobe.doCopy) begin
      for (int l = 0; l < L; l++)
        for (int s = 0; s < NST; s++)
          tagMem[l][s] <= tagMem[copyParents[l*PW +: PW]][s];
    end else if (strobe.doWrite) begin
      tagMem[wrPath][wIdx] <= wrPath;
    end
  end

  for (genvar l = 0; l < L; l++) begin : g_rd
    assign rdPtr[l*PW +: PW] = rdOk ? tagMem[l][rIdx] : '0;
  end
endmodule

// File: rtl/path_ptr_table.sv
module path_ptr_table
  import path_ptr_pkg::*;
#(
  parameter int L     = 4,
  parameter int LOG_N = 4,
  localparam int PW   = (L > 1) ? $clog2(L) : 1,
  localparam int SW   = $clog2(LOG_N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startCw,
  input  logic             wrEn,
  input  logic [PW-1:0]    wrPath,
  input  logic [SW-1:0]    wrStage,
  input  logic             copyEn,
  input  logic [L*PW-1:0]  copyParents,
  input  logic [SW-1:0]    rdStage,
  output logic [L*PW-1:0]  rdPtr,
  input  logic             bitDone,
  input  logic             bitFrozen,
  output logic [LOG_N-1:0] bitIdx,
  output logic [SW-1:0]    topStage,
  output logic             selNeeded
);
  ptr_strobe_t strobe;

  path_ptr_ctrl #(.L(L), .LOG_N(LOG_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCw(startCw), .wrEn(wrEn),
    .wrStage(wrStage), .copyEn(copyEn), .bitDone(bitDone),
    .bitFrozen(bitFrozen), .strobe(strobe), .bitIdx(bitIdx),
    .topStage(topStage), .selNeeded(selNeeded)
  );

  path_ptr_dp #(.L(L), .LOG_N(LOG_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPath(wrPath),
    .wrStage(wrStage), .copyParents(copyParents), .rdStage(rdStage),
    .rdPtr(rdPtr)
  );
endmodule

module path_ptr_table_chk #(
  parameter int L     = 4,
  parameter int LOG_N = 4,
  localparam int PW   = (L > 1) ? $clog2(L) : 1,
  localparam int SW   = $clog2(LOG_N + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startCw,
  input logic             wrEn,
  input logic [PW-1:0]    wrPath,
  input logic [SW-1:0]    wrStage,
  input logic             copyEn,
  input logic [L*PW-1:0]  copyParents,
  input logic [SW-1:0]    rdStage,
  input logic [L*PW-1:0]  rdPtr,
  input logic             bitDone,
  input logic             bitFrozen,
  input logic [LOG_N-1:0] bitIdx,
  input logic [SW-1:0]    topStage,
  input logic             selNeeded
);
  localparam logic [SW-1:0] LAST_STAGE = SW'(LOG_N - 1);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(startCw) |-> (rdPtr == '0) && (bitIdx == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(wrEn && !copyEn && !startCw) &&
    (rdStage == $past(wrStage)) && (rdStage != '0) && (rdStage <= LAST_STAGE)
    |-> PW'(rdPtr >> (PW * $past(wrPath))) == $past(wrPath)); // R3

  for (genvar l = 0; l < L; l++) begin : g_cp
    AST_COPY_ROW: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) && $past(copyEn && !startCw) && $stable(rdStage)
      |-> rdPtr[l*PW +: PW] ==
          PW'($past(rdPtr) >> (PW * $past(copyParents[l*PW +: PW])))); // R4
  end

  AST_UNTAGGED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStage == '0) || (rdStage > LAST_STAGE) |-> rdPtr == '0); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(bitDone && !startCw) |-> bitIdx == $past(bitIdx) + 1'b1); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(!bitDone && !startCw) |-> $stable(bitIdx)); // R6

  AST_TOP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx == '0 |-> topStage == SW'(LOG_N)); // R7

  AST_TOP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (topStage != '0) && (topStage <= SW'(LOG_N))); // R7

  AST_SEL_INFO: assert property (@(posedge clk) disable iff (!rstN)
    !bitFrozen |-> selNeeded); // R8

  AST_SEL_LAST: assert property (@(posedge clk) disable iff (!rstN)
    &bitIdx |-> selNeeded); // R8
endmodule

bind path_ptr_table path_ptr_table_chk #(.L(L), .LOG_N(LOG_N)) u_chk (
  .clk(clk), .rstN(rstN), .startCw(startCw), .wrEn(wrEn), .wrPath(wrPath),
  .wrStage(wrStage), .copyEn(copyEn), .copyParents(copyParents),
  .rdStage(rdStage), .rdPtr(rdPtr), .bitDone(bitDone), .bitFrozen(bitFrozen),
  .bitIdx(bitIdx), .topStage(topStage), .selNeeded(selNeeded)
);

// File: tb/path_ptr_table_tb.sv
`timescale 1ns/100ps
module path_ptr_table_tb;
  localparam int L = 4;
  localparam int LOG_N = 4;
  localparam int N = 1 << LOG_N;
  localparam int PW = 2;
  localparam int SW = 3;
  localparam int NST = LOG_N - 1;

  logic clk = 0, rstN = 0;
  logic startCw = 0, wrEn = 0, copyEn = 0, bitDone = 0, bitFrozen = 0;
  logic [PW-1:0] wrPath = '0;
  logic [SW-1:0] wrStage = '0, rdStage = '0;
  logic [L*PW-1:0] copyParents = '0;
  logic [L*PW-1:0] rdPtr;
  logic [LOG_N-1:0] bitIdx;
  logic [SW-1:0] topStage;
  logic selNeeded;

  int checks = 0, fails = 0;
  bit done = 0;
  int refTag [L][NST];

  always #5 clk = ~clk;

  path_ptr_table #(.L(L), .LOG_N(LOG_N)) u_dut (
    .clk(clk), .rstN(rstN), .startCw(startCw), .wrEn(wrEn), .wrPath(wrPath),
    .wrStage(wrStage), .copyEn(copyEn), .copyParents(copyParents),
    .rdStage(rdStage), .rdPtr(rdPtr), .bitDone(bitDone), .bitFrozen(bitFrozen),
    .bitIdx(bitIdx), .topStage(topStage), .selNeeded(selNeeded)
  );

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sweep all stages, including untagged ones, against the model. R2
  task automatic sweepTags(input string req);
    for (int st = 0; st <= LOG_N; st++) begin
      rdStage = SW'(st);
      #0.2;
      for (int l = 0; l < L; l++) begin
        int exp;
        exp = (st >= 1 && st <= NST) ? refTag[l][st-1] : 0;
        cmp(req, int'(rdPtr[l*PW +: PW]), exp);
      end
    end
  endtask

  task automatic clearModel();
    for (int l = 0; l < L; l++)
      for (int s = 0; s < NST; s++) refTag[l][s] = 0;
  endtask

  // One strobe cycle: drive at falling edge, release at next falling edge.
  task automatic pulse(input bit st, input bit we, input int wp, input int ws,
                       input bit ce, input int par [L]);
    startCw = st; wrEn = we; wrPath = PW'(wp); wrStage = SW'(ws); copyEn = ce;
    for (int l = 0; l < L; l++) copyParents[l*PW +: PW] = PW'(par[l]);
    @(posedge clk);
    @(negedge clk);
    startCw = 0; wrEn = 0; copyEn = 0;
    if (st) clearModel();
    else if (ce) begin
      int old [L][NST];
      old = refTag;
      for (int l = 0; l < L; l++)
        for (int s = 0; s < NST; s++) refTag[l][s] = old[par[l]][s];
    end else if (we && ws >= 1 && ws <= NST) refTag[wp][ws-1] = wp;
  endtask

  initial begin
    int par [L];
    int expTop;
    for (int l = 0; l < L; l++) par[l] = l;
    clearModel();
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    sweepTags("R1 reset");
    cmp("R1 counter reset", int'(bitIdx), 0);

    // Every path writes every stage value, including the ignored ones. R3
    for (int w = 0; w < L; w++)
      for (int s = 0; s <= LOG_N + 2; s++) begin
        if (s <= 7) begin
          pulse(0, 1, w, s, 0, par);
          sweepTags("R3 write");
        end
      end
    // Force distinct rows: path 1 only at stage 2, path 3 at stages 1 and 3
    pulse(1, 0, 0, 0, 0, par);
    sweepTags("R1 start");
    pulse(0, 1, 1, 2, 0, par);
    pulse(0, 1, 3, 1, 0, par);
    pulse(0, 1, 3, 3, 0, par);
    pulse(0, 1, 2, 2, 0, par);
    sweepTags("R3 rows");
    // Rotation: each row takes its neighbour's old row. R4
    par = '{1, 2, 3, 0};
    pulse(0, 0, 0, 0, 1, par);
    sweepTags("R4 rotate");
    par = '{3, 3, 0, 1};
    pulse(0, 0, 0, 0, 1, par);
    sweepTags("R4 overlap");
    par = '{2, 2, 2, 2};
    pulse(0, 0, 0, 0, 1, par);
    sweepTags("R4 broadcast");
    // Copy beats write; start beats both. R5
    par = '{0, 1, 2, 3};
    pulse(0, 1, 1, 1, 1, par);
    sweepTags("R5 copy over write");
    pulse(0, 1, 3, 2, 0, par);
    par = '{3, 3, 3, 3};
    pulse(1, 1, 2, 1, 1, par);
    sweepTags("R5 start over all");

    // Mixed pseudo-random traffic.
    for (int k = 0; k < 300; k++) begin
      int op;
      op = int'($urandom_range(0, 9));
      for (int l = 0; l < L; l++) par[l] = int'($urandom_range(0, L-1));
      pulse(op == 0, op < 7, int'($urandom_range(0, L-1)),
            int'($urandom_range(0, LOG_N)), op >= 5, par);
      sweepTags("R4 R3 random");
    end

    // Bit counter, schedule and selection flag over a full codeword. R6 R7 R8
    pulse(1, 0, 0, 0, 0, par);
    for (int i = 0; i < N + 3; i++) begin
      int iw;
      iw = i % N;
      cmp("R6 bit index", int'(bitIdx), iw);
      expTop = LOG_N;
      for (int b = 0; b < LOG_N; b++) if ((iw >> b) & 1) expTop = LOG_N - b;
      cmp("R7 top stage", int'(topStage), expTop);
      bitFrozen = 1; #0.2;
      cmp("R8 frozen", int'(selNeeded), (iw == N-1) ? 1 : 0);
      bitFrozen = 0; #0.2;
      cmp("R8 info", int'(selNeeded), 1);
      @(posedge clk); @(negedge clk);
      cmp("R6 hold", int'(bitIdx), iw);
      bitDone = 1;
      @(posedge clk); @(negedge clk);
      bitDone = 0;
    end
    pulse(1, 0, 0, 0, 0, par);
    cmp("R6 restart", int'(bitIdx), 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule